// File: doc/BRIEF.md
# Synchronous Burst SRAM Address Controller

This block is the control front end of a synchronous burst SRAM. On a clock edge where one of two active-low address strobes is asserted, it captures an external word address and opens a read or a write cycle. It then walks the two low address bits through a four-beat burst. One strobe is the processor strobe, which always opens a read. The other is the controller strobe, which opens a read or a write depending on the write controls sampled with it. A static mode pin picks a linear or an interleaved burst order. An active-low advance input steps the burst, and holding it high inserts wait beats.

The chip is selected only when its active-high and active-low chip enables are both asserted at the strobe. A strobe that arrives while the chip is unselected closes the current cycle and leaves the chip deselected. Writes update an 18-bit word in two 9-bit byte lanes. Per-lane enables pick which lanes change, and a global write forces both lanes. A snooze input freezes the controller and turns the output drivers off. An asynchronous output enable gates the read drivers. A small behavioural array behind the controller holds the data.

Top module: `bsram_ctrl`

## Requirements
- R1: After reset no cycle is open: `dout_en` is 0 even while `oe_n` is low.
- R2: A clock edge with `adsp_n` low, `ce_n` low, `ce` high and `zz` low loads `addr_i` into `burst_addr` and opens a read cycle, whatever the write controls. From the next cycle, with `oe_n` low, `dout_en` is 1 and `dout` shows the word at `burst_addr`.
- R3: A clock edge with `adsc_n` low and the chip enabled loads `addr_i`. It opens a write cycle when `gw_n` is low, or when `bwe_n` is low and at least one `bw_n` bit is low. Otherwise it opens a read cycle. In a write cycle, `dout_en` is 0 and each later edge writes `din` to `burst_addr`.
- R4: A strobe taken while `ce` is low or `ce_n` is high deselects the chip. `dout_en` stays 0 and no word is written until the next enabled strobe.
- R5: In an open cycle, an edge with `adv_n` low (and no strobe) steps the burst. With `adv_n` high, `burst_addr` holds its value.
- R6: With `mode` low, the low two bits of `burst_addr` on beat k are (loaded bits + k) mod 4. The upper bits stay at their loaded value.
- R7: With `mode` high, the low two bits on beat k are the loaded bits XOR k.
- R8: After four steps the burst wraps, and `burst_addr` equals the loaded address again.
- R9: When both strobes are low in one edge, the processor strobe wins and a read opens. With `ce_n` high, the processor strobe is ignored and the open cycle and its address are kept.
- R10: On a write edge with `gw_n` high and `bwe_n` low, lane i (bits 9i+8 down to 9i) is written only where `bw_n[i]` is 0. With `gw_n` low, both lanes are written.
- R11: `oe_n` high forces `dout_en` to 0 in the same cycle, without waiting for a clock edge.
- R12: While `zz` is high, strobes, steps and writes are ignored and `dout_en` is 0. In the first cycle after `zz` falls, the cycle that was open before snooze resumes at the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the control state |
| addr_i | input | 6 | External word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce | input | 1 | Chip enable, active high |
| ce_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write master enable, active low |
| bw_n | input | 2 | Per-lane write enables, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| zz | input | 1 | Snooze request, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | 18 | Write data |
| dout | output | 18 | Read data at the current burst address |
| dout_en | output | 1 | Read drivers on; 0 means high impedance |
| burst_addr | output | 6 | Current burst word address |

## Verification
If the burst counter or the loaded base bits are wrong, `burst_addr` shows it on the first beat after the fault. Because `dout` follows that address, a read returns the wrong word in the same cycle. A wrong cycle kind shows up on `dout_en` one cycle after the strobe: a read that should have opened, or a write that leaked. A corrupted lane mask or a write that should have been suppressed stays hidden until the word is read back. For that reason, every order and base combination is written and then read through both strobes.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  // Low two address bits for beat cnt of a burst loaded at base.
  function automatic logic [1:0] beat_offset(input logic interleave,
                                             input logic [1:0] base,
                                             input logic [1:0] cnt);
    logic [1:0] r;
    if (interleave) r = base ^ cnt;
    else            r = base + cnt;
    return r;
  endfunction

endpackage

// File: rtl/bsram_cycle_ctl.sv
module bsram_cycle_ctl
  import bsram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adsp_n,
  input  logic adsc_n,
  input  logic ce,
  input  logic ce_n,
  input  logic zz,
  input  logic wr_req,
  output logic load,
  output cyc_e cyc
);

  logic strobe_p;
  logic strobe_c;
  logic chip_en;

  assign strobe_p = !adsp_n && !ce_n && !zz;
  assign strobe_c = !adsc_n && !strobe_p && !zz;
  assign chip_en  = ce && !ce_n;
  assign load     = strobe_p || strobe_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= CYC_IDLE;
    end else if (load) begin
      if (!chip_en)                 cyc <= CYC_IDLE;
      else if (strobe_c && wr_req)  cyc <= CYC_WRITE;
      else                          cyc <= CYC_READ;
    end
  end

  // R2
  proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !ce_n && ce && !zz) |=> (cyc == CYC_READ));

  // R12
  snooze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> $stable(cyc));

endmodule

// File: rtl/bsram_burst.sv
module bsram_burst
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step,
  input  logic              interleave,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int UP_W = ADDR_W - 2;

  logic [UP_W-1:0] upper;
  logic [1:0]      base;
  logic [1:0]      cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper <= '0;
      base  <= '0;
      cnt   <= '0;
    end else if (load) begin
      upper <= addr_i[ADDR_W-1:2];
      base  <= addr_i[1:0];
      cnt   <= '0;
    end else if (step) begin
      cnt <= cnt + 2'd1;
    end
  end

  assign cur_addr = {upper, beat_offset(interleave, base, cnt)};

  // R5
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> ($stable(cnt) && $stable(base) && $stable(upper)));

  // R8
  burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt == 2'd3) |=> (cnt == 2'd0));

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic [LANES-1:0]         lane_we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  wdata,
  output logic [LANES*LANE_W-1:0]  rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = mem[addr];
  end

endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    ce,
  input  logic                    ce_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    mode,
  input  logic                    zz,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en,
  output logic [ADDR_W-1:0]       burst_addr
);

  logic             wr_req;
  logic             load;
  cyc_e             cyc;
  logic             step;
  logic             write_beat;
  logic [LANES-1:0] lane_we;

  assign wr_req = !gw_n || (!bwe_n && !(&bw_n));

  bsram_cycle_ctl u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .adsp_n (adsp_n),
    .adsc_n (adsc_n),
    .ce     (ce),
    .ce_n   (ce_n),
    .zz     (zz),
    .wr_req (wr_req),
    .load   (load),
    .cyc    (cyc)
  );

  assign step = (cyc != CYC_IDLE) && !adv_n && !load && !zz;

  bsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .addr_i     (addr_i),
    .step       (step),
    .interleave (mode),
    .cur_addr   (burst_addr)
  );

  assign write_beat = (cyc == CYC_WRITE) && !load && !zz;
  assign lane_we = !write_beat ? '0 :
                   !gw_n       ? '1 :
                   !bwe_n      ? ~bw_n : '0;

  bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .lane_we (lane_we),
    .addr    (burst_addr),
    .wdata   (din),
    .rdata   (dout)
  );

  assign dout_en = (cyc == CYC_READ) && !oe_n && !zz;

  // R11
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  // R12
  snooze_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zz |-> (lane_we == '0 && !dout_en));

  // R3
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |-> !dout_en);

endmodule

// File: tb/bsram_ctrl_bench.sv
module bsram_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr_i;
  logic        adsp_n, adsc_n, adv_n, ce, ce_n, gw_n, bwe_n, mode, zz, oe_n;
  logic [1:0]  bw_n;
  logic [17:0] din;
  logic [17:0] dout;
  logic        dout_en;
  logic [5:0]  burst_addr;

  int checks = 0;
  int failures = 0;
  logic [17:0] model [64];

  always #5 clk = ~clk;

  bsram_ctrl u_bsram_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce(ce), .ce_n(ce_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .mode(mode), .zz(zz), .oe_n(oe_n), .din(din), .dout(dout),
    .dout_en(dout_en), .burst_addr(burst_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Expected beat address, stated arithmetically.
  function automatic logic [5:0] exp_addr(input logic m, input logic [5:0] a, input int k);
    int lo;
    if (m) lo = ((a[1] ^ ((k >> 1) & 1)) * 2) + (a[0] ^ (k & 1));
    else   lo = (int'(a[1:0]) + k) % 4;
    return {a[5:2], 2'(lo)};
  endfunction

  task automatic write_burst(input logic m, input logic [5:0] a);
    mode = m; addr_i = a; adsc_n = 1'b0; gw_n = 1'b0;
    step();
    adsc_n = 1'b1;
    chk("R3 write cycle drivers off", 32'(dout_en), 32'd0);
    for (int k = 0; k < 4; k++) begin
      din = 18'(m * 20000 + int'(a) * 97 + k * 13 + 5);
      adv_n = 1'b0;
      chk(m ? "R7 write beat addr" : "R6 write beat addr", 32'(burst_addr), 32'(exp_addr(m, a, k)));
      model[exp_addr(m, a, k)] = din;
      step();
    end
    chk("R8 wrap to loaded addr", 32'(burst_addr), 32'(a));
    gw_n = 1'b1; adv_n = 1'b1;
  endtask

  task automatic read_burst(input logic m, input logic [5:0] a, input logic hold);
    mode = m; addr_i = a; adsp_n = 1'b0; gw_n = 1'b0;
    step();
    adsp_n = 1'b1; gw_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk("R2 read drivers on", 32'(dout_en), 32'd1);
      chk(m ? "R7 read beat addr" : "R6 read beat addr", 32'(burst_addr), 32'(exp_addr(m, a, k)));
      chk("R2 read data", 32'(dout), 32'(model[exp_addr(m, a, k)]));
      if (hold && k == 1) begin
        adv_n = 1'b1;
        step();
        chk("R5 wait beat holds", 32'(burst_addr), 32'(exp_addr(m, a, k)));
      end
      adv_n = 1'b0;
      step();
    end
    adv_n = 1'b1;
    chk("R8 read wrap", 32'(burst_addr), 32'(a));
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr_i = '0; adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    ce = 1'b1; ce_n = 1'b0; gw_n = 1'b1; bwe_n = 1'b1; bw_n = 2'b11;
    mode = 1'b0; zz = 1'b0; oe_n = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset drivers off", 32'(dout_en), 32'd0);
    rst_n = 1'b1;
    step();
    chk("R1 idle after reset", 32'(dout_en), 32'd0);

    // Sweep order x base x upper bits.
    for (int m = 0; m < 2; m++)
      for (int b = 0; b < 4; b++)
        write_burst(1'(m), {4'(m * 4 + b + 1), 2'(b)});
    for (int m = 0; m < 2; m++)
      for (int b = 0; b < 4; b++)
        read_burst(1'(m), {4'(m * 4 + b + 1), 2'(b)}, 1'(b[0]));

    // R10: lane 0 only via byte enables.
    mode = 1'b0; addr_i = 6'h04; adsc_n = 1'b0; bwe_n = 1'b0; bw_n = 2'b10;
    step();
    adsc_n = 1'b1; din = 18'h3FFFF;
    step();
    model[6'h04][8:0] = 9'h1FF;
    bwe_n = 1'b1; bw_n = 2'b11;
    read_burst(1'b0, 6'h04, 1'b0);
    // R10: lane 1 only.
    addr_i = 6'h05; adsc_n = 1'b0; bwe_n = 1'b0; bw_n = 2'b01;
    step();
    adsc_n = 1'b1; din = 18'h00000;
    step();
    model[6'h05][17:9] = 9'h000;
    bwe_n = 1'b1; bw_n = 2'b11;
    read_burst(1'b0, 6'h04, 1'b0);
    // R10: global write overrides lane enables.
    addr_i = 6'h06; adsc_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b1; bw_n = 2'b11;
    step();
    adsc_n = 1'b1; din = 18'h2AAAA;
    step();
    model[6'h06] = 18'h2AAAA;
    gw_n = 1'b1;
    read_burst(1'b0, 6'h04, 1'b0);

    // R3: controller strobe without write controls opens a read.
    addr_i = 6'h09; adsc_n = 1'b0;
    step();
    adsc_n = 1'b1;
    chk("R3 read via controller strobe", 32'(dout_en), 32'd1);
    chk("R3 read data", 32'(dout), 32'(model[6'h09]));

    // R4: deselect with ce low, then try a write beat.
    addr_i = 6'h08; adsc_n = 1'b0; ce = 1'b0; gw_n = 1'b0;
    step();
    adsc_n = 1'b1; ce = 1'b1; din = 18'h12345; adv_n = 1'b0;
    chk("R4 deselected drivers off", 32'(dout_en), 32'd0);
    step();
    gw_n = 1'b1; adv_n = 1'b1;
    // R4: deselect with ce_n high via controller strobe.
    addr_i = 6'h0A; adsc_n = 1'b0; ce_n = 1'b1; gw_n = 1'b0;
    step();
    adsc_n = 1'b1; ce_n = 1'b0; din = 18'h0BEEF;
    chk("R4 ce_n deselect drivers off", 32'(dout_en), 32'd0);
    step();
    gw_n = 1'b1;
    read_burst(1'b0, 6'h08, 1'b0);

    // R9: both strobes with write controls -> read.
    addr_i = 6'h1C; adsp_n = 1'b0; adsc_n = 1'b0; gw_n = 1'b0;
    step();
    adsp_n = 1'b1; adsc_n = 1'b1; gw_n = 1'b1;
    chk("R9 processor strobe wins", 32'(dout_en), 32'd1);
    chk("R9 address loaded", 32'(burst_addr), 32'h1C);
    // R9: processor strobe ignored while ce_n high.
    addr_i = 6'h30; adsp_n = 1'b0; ce_n = 1'b1;
    step();
    adsp_n = 1'b1;
    chk("R9 ignored strobe keeps addr", 32'(burst_addr), 32'h1C);
    ce_n = 1'b0;
    chk("R9 ignored strobe keeps read", 32'(dout_en), 32'd1);

    // R11: asynchronous output enable.
    oe_n = 1'b1;
    #1;
    chk("R11 oe_n high drivers off", 32'(dout_en), 32'd0);
    oe_n = 1'b0;
    #1;
    chk("R11 oe_n low drivers on", 32'(dout_en), 32'd1);

    // R12: snooze ignores strobe, step and write.
    zz = 1'b1; addr_i = 6'h31; adsp_n = 1'b0; adv_n = 1'b0;
    #1;
    chk("R12 snooze drivers off", 32'(dout_en), 32'd0);
    step();
    chk("R12 snooze drivers off after edge", 32'(dout_en), 32'd0);
    zz = 1'b0; adsp_n = 1'b1; adv_n = 1'b1;
    #1;
    chk("R12 resume addr", 32'(burst_addr), 32'h1C);
    chk("R12 resume read", 32'(dout_en), 32'd1);
    chk("R12 resume data", 32'(dout), 32'(model[6'h1C]));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule